// File: doc/BRIEF.md
# Inclusive Second-Level Synonym Back-Pointer Directory

This block holds the back-pointer for every line of a physically addressed, inclusive second-level cache. A back-pointer is a valid flag, a flag naming the first-level cache that holds the copy (instruction or data), and the line slot inside that cache. Because each second-level line can point at only one first-level slot, at most one virtual alias of a physical line sits in the first level at any time. The rule also covers the two first-level caches together, so instruction and data copies stay consistent.

Four kinds of request reach the controller. A first-level miss (already resolved to a second-level line by the tag lookup upstream) either gets a grant straight away or, if a first-level copy exists, triggers a move command to that copy and waits for it. A snooped bus write invalidates the first-level copy. A snooped bus read has the copy supply its data and then drop it. A second-level eviction invalidates the first-level copy before it completes. All first-level commands use a request/acknowledge handshake, and the controller accepts no new request while one is outstanding. A directory port lets the surrounding cache logic read any pointer and write pointers when the controller is quiet. The controller steps through four named states: IDLE, MISS_WAIT (move outstanding), SNOOP_WAIT (invalidate or supply outstanding) and EVICT_WAIT (invalidate outstanding). The transitions are IDLE→MISS_WAIT on a miss whose pointer is valid, IDLE→SNOOP_WAIT on a snoop whose pointer is valid, IDLE→EVICT_WAIT on an eviction whose pointer is valid, and each wait state→IDLE on the cycle the acknowledge is seen. A request whose pointer is invalid is finished in IDLE without leaving it.

Top module: `synonym_bp_dir`

## Requirements
- R1: After reset every pointer reads invalid (all zero), `l1_cmd_req` is low, and `miss_ready`, `snoop_ready` and `evict_ready` are high when no request is presented.
- R2: A miss accepted on a line with an invalid pointer raises `fill_grant` for one cycle, starting the cycle after acceptance, with `fill_from_l1` = 0. From that same cycle the pointer reads valid with the requester's cache flag and slot.
- R3: A miss accepted on a line with a valid pointer raises `l1_cmd_req` the next cycle with op MOVE (2'b10), naming the pointed cache and slot. `fill_grant` stays low until the acknowledge.
- R4: In the cycle after a MOVE is acknowledged, `fill_grant` = 1 and `fill_from_l1` = 1, and `fill_src_side`/`fill_src_loc` name the old copy. From that cycle the pointer names the requester. This makes the move the only first-level copy.
- R5: While `l1_cmd_req` is high and not acknowledged, the op, cache flag and slot hold stable, and all three ready outputs are low.
- R6: A snooped write that finds a valid pointer issues op INVAL (2'b01). The cycle after the acknowledge, `snoop_done` pulses and the pointer reads zero.
- R7: A snooped read that finds a valid pointer issues op SUPPLY (2'b11). The cycle after the acknowledge, `snoop_done` pulses and the pointer reads zero.
- R8: A snoop or eviction that finds an invalid pointer pulses its done output the cycle after acceptance and issues no command.
- R9: An eviction that finds a valid pointer issues INVAL to that copy. `evict_done` stays low until the cycle after the acknowledge, and from then the pointer reads zero.
- R10: When several requests are presented in IDLE, the snoop is taken first, then the eviction, then the miss. A lower-priority request's ready stays low while a higher one is presented.
- R11: `dir_rdata` shows the pointer at `dir_addr` in the same cycle. The packing is bit 6 = valid, bit 5 = cache flag (1 = data, 0 = instruction), bits 4:0 = slot. A write via `dir_we` takes effect only when the controller is in IDLE with no request presented; otherwise it is ignored.
- R12: The cache flag is honoured across caches. An instruction-side miss on a line held by the data cache moves it from the data cache, and the pointer then names the instruction cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | First-level miss presented |
| miss_ready | output | 1 | Miss accepted this cycle if valid |
| miss_line | input | 6 | Second-level line of the miss |
| miss_side | input | 1 | Requesting cache, 1 = data |
| miss_loc | input | 5 | Requesting first-level slot |
| fill_grant | output | 1 | One-cycle grant of the fill |
| fill_from_l1 | output | 1 | Data comes from a moved first-level copy |
| fill_src_side | output | 1 | Cache of the moved copy |
| fill_src_loc | output | 5 | Slot of the moved copy |
| snoop_valid | input | 1 | Snoop presented |
| snoop_is_write | input | 1 | 1 = bus write, 0 = bus read |
| snoop_line | input | 6 | Second-level line snooped |
| snoop_ready | output | 1 | Snoop accepted this cycle if valid |
| snoop_done | output | 1 | One-cycle snoop completion |
| evict_valid | input | 1 | Eviction presented |
| evict_line | input | 6 | Second-level line evicted |
| evict_ready | output | 1 | Eviction accepted this cycle if valid |
| evict_done | output | 1 | One-cycle eviction completion |
| dir_we | input | 1 | Directory write enable |
| dir_addr | input | 6 | Directory read/write line |
| dir_wdata | input | 7 | Pointer to write |
| dir_rdata | output | 7 | Pointer at `dir_addr` |
| l1_cmd_req | output | 1 | First-level command request |
| l1_cmd_op | output | 2 | 01 INVAL, 10 MOVE, 11 SUPPLY |
| l1_cmd_side | output | 1 | Target cache, 1 = data |
| l1_cmd_loc | output | 5 | Target first-level slot |
| l1_cmd_ack | input | 1 | Command acknowledge |

## Verification
The bench drives inputs on the falling edge and samples on the next falling edge. Each check therefore lands exactly one rising edge after the event it depends on. Grants and done pulses for invalid pointers, and command requests for valid ones, are due one edge after acceptance. Grants and done pulses after a command are due one edge after the edge that saw the acknowledge. Directory contents are read combinationally at those same sample points. Each scenario also samples the cycle before the pulse or after it, to show that the pulse is one cycle long and that a command is held while the acknowledge is withheld.

// File: rtl/synonym_bp_pkg.sv
package synonym_bp_pkg;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_INVAL  = 2'b01,
        OP_MOVE   = 2'b10,
        OP_SUPPLY = 2'b11
    } l1_op_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'b00,
        ST_MISS_WAIT  = 2'b01,
        ST_SNOOP_WAIT = 2'b10,
        ST_EVICT_WAIT = 2'b11
    } bp_state_e;

    localparam logic SIDE_INSTR = 1'b0;
    localparam logic SIDE_DATA  = 1'b1;

endpackage

// File: rtl/synonym_bp_store.sv
module synonym_bp_store #(
    parameter int L2_LINES = 64,
    parameter int ENT_W    = 7,
    localparam int AW      = $clog2(L2_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [ENT_W-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [ENT_W-1:0] rdata_b
);

    logic [ENT_W-1:0] mem_q [L2_LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < L2_LINES; i++) begin
                mem_q[i] <= '0;
            end
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/synonym_bp_ctrl.sv
module synonym_bp_ctrl
    import synonym_bp_pkg::*;
#(
    parameter int L2_LINES = 64,
    parameter int L1_LINES = 32,
    localparam int AW      = $clog2(L2_LINES),
    localparam int LW      = $clog2(L1_LINES),
    localparam int ENT_W   = LW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [AW-1:0]    miss_line,
    input  logic             miss_side,
    input  logic [LW-1:0]    miss_loc,
    output logic             miss_ready,
    input  logic             snoop_valid,
    input  logic             snoop_is_write,
    input  logic [AW-1:0]    snoop_line,
    output logic             snoop_ready,
    input  logic             evict_valid,
    input  logic [AW-1:0]    evict_line,
    output logic             evict_ready,
    input  logic             ext_we,
    input  logic [AW-1:0]    ext_addr,
    input  logic [ENT_W-1:0] ext_wdata,
    output logic [AW-1:0]    look_addr,
    input  logic [ENT_W-1:0] look_entry,
    output logic             st_we,
    output logic [AW-1:0]    st_addr,
    output logic [ENT_W-1:0] st_wdata,
    output logic             fill_grant,
    output logic             fill_from_l1,
    output logic             fill_src_side,
    output logic [LW-1:0]    fill_src_loc,
    output logic             snoop_done,
    output logic             evict_done,
    output logic             cmd_req,
    output l1_op_e           cmd_op,
    output logic             cmd_side,
    output logic [LW-1:0]    cmd_loc,
    input  logic             cmd_ack
);

    bp_state_e state_q, state_d;

    logic          is_idle;
    logic          take_snoop, take_evict, take_miss, no_req;
    logic          look_v, look_side;
    logic [LW-1:0] look_loc;
    logic          ack_hs;

    logic [AW-1:0] pend_line_q;
    logic          pend_side_q;
    logic [LW-1:0] pend_loc_q;

    logic          cmd_req_q;
    l1_op_e        cmd_op_q;
    logic          cmd_side_q;
    logic [LW-1:0] cmd_loc_q;
    logic          fill_grant_q, fill_from_l1_q, fill_src_side_q;
    logic [LW-1:0] fill_src_loc_q;
    logic          snoop_done_q, evict_done_q;

    assign is_idle    = (state_q == ST_IDLE);
    assign take_snoop = is_idle && snoop_valid;
    assign take_evict = is_idle && !snoop_valid && evict_valid;
    assign take_miss  = is_idle && !snoop_valid && !evict_valid && miss_valid;
    assign no_req     = !snoop_valid && !evict_valid && !miss_valid;

    assign snoop_ready = is_idle;
    assign evict_ready = is_idle && !snoop_valid;
    assign miss_ready  = is_idle && !snoop_valid && !evict_valid;

    assign look_addr = snoop_valid ? snoop_line : (evict_valid ? evict_line : miss_line);
    assign look_v    = look_entry[ENT_W-1];
    assign look_side = look_entry[LW];
    assign look_loc  = look_entry[LW-1:0];
    assign ack_hs    = cmd_req_q && cmd_ack;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_snoop && look_v) begin
                    state_d = ST_SNOOP_WAIT;
                end else if (take_evict && look_v) begin
                    state_d = ST_EVICT_WAIT;
                end else if (take_miss && look_v) begin
                    state_d = ST_MISS_WAIT;
                end
            end
            ST_MISS_WAIT, ST_SNOOP_WAIT, ST_EVICT_WAIT: begin
                if (ack_hs) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Directory update
    always_comb begin
        st_we    = 1'b0;
        st_addr  = pend_line_q;
        st_wdata = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_miss && !look_v) begin
                    st_we    = 1'b1;
                    st_addr  = miss_line;
                    st_wdata = {1'b1, miss_side, miss_loc};
                end else if (take_evict && !look_v) begin
                    st_we    = 1'b1;
                    st_addr  = evict_line;
                end else if (no_req && ext_we) begin
                    st_we    = 1'b1;
                    st_addr  = ext_addr;
                    st_wdata = ext_wdata;
                end
            end
            ST_MISS_WAIT: begin
                if (ack_hs) begin
                    st_we    = 1'b1;
                    st_wdata = {1'b1, pend_side_q, pend_loc_q};
                end
            end
            ST_SNOOP_WAIT, ST_EVICT_WAIT: begin
                st_we = ack_hs;
            end
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_line_q     <= '0;
            pend_side_q     <= 1'b0;
            pend_loc_q      <= '0;
            cmd_req_q       <= 1'b0;
            cmd_op_q        <= OP_NONE;
            cmd_side_q      <= 1'b0;
            cmd_loc_q       <= '0;
            fill_grant_q    <= 1'b0;
            fill_from_l1_q  <= 1'b0;
            fill_src_side_q <= 1'b0;
            fill_src_loc_q  <= '0;
            snoop_done_q    <= 1'b0;
            evict_done_q    <= 1'b0;
        end else begin
            fill_grant_q <= 1'b0;
            snoop_done_q <= 1'b0;
            evict_done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (take_snoop) begin
                        pend_line_q <= snoop_line;
                        if (look_v) begin
                            cmd_req_q  <= 1'b1;
                            cmd_op_q   <= snoop_is_write ? OP_INVAL : OP_SUPPLY;
                            cmd_side_q <= look_side;
                            cmd_loc_q  <= look_loc;
                        end else begin
                            snoop_done_q <= 1'b1;
                        end
                    end else if (take_evict) begin
                        pend_line_q <= evict_line;
                        if (look_v) begin
                            cmd_req_q  <= 1'b1;
                            cmd_op_q   <= OP_INVAL;
                            cmd_side_q <= look_side;
                            cmd_loc_q  <= look_loc;
                        end else begin
                            evict_done_q <= 1'b1;
                        end
                    end else if (take_miss) begin
                        pend_line_q <= miss_line;
                        pend_side_q <= miss_side;
                        pend_loc_q  <= miss_loc;
                        if (look_v) begin
                            cmd_req_q  <= 1'b1;
                            cmd_op_q   <= OP_MOVE;
                            cmd_side_q <= look_side;
                            cmd_loc_q  <= look_loc;
                        end else begin
                            fill_grant_q    <= 1'b1;
                            fill_from_l1_q  <= 1'b0;
                            fill_src_side_q <= 1'b0;
                            fill_src_loc_q  <= '0;
                        end
                    end
                end
                ST_MISS_WAIT: begin
                    if (ack_hs) begin
                        cmd_req_q       <= 1'b0;
                        fill_grant_q    <= 1'b1;
                        fill_from_l1_q  <= 1'b1;
                        fill_src_side_q <= cmd_side_q;
                        fill_src_loc_q  <= cmd_loc_q;
                    end
                end
                ST_SNOOP_WAIT: begin
                    if (ack_hs) begin
                        cmd_req_q    <= 1'b0;
                        snoop_done_q <= 1'b1;
                    end
                end
                ST_EVICT_WAIT: begin
                    if (ack_hs) begin
                        cmd_req_q    <= 1'b0;
                        evict_done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign cmd_req       = cmd_req_q;
    assign cmd_op        = cmd_op_q;
    assign cmd_side      = cmd_side_q;
    assign cmd_loc       = cmd_loc_q;
    assign fill_grant    = fill_grant_q;
    assign fill_from_l1  = fill_from_l1_q;
    assign fill_src_side = fill_src_side_q;
    assign fill_src_loc  = fill_src_loc_q;
    assign snoop_done    = snoop_done_q;
    assign evict_done    = evict_done_q;

    // R5
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_req_q && !cmd_ack) |=> (cmd_req_q && $stable(cmd_op_q)
                                     && $stable(cmd_side_q) && $stable(cmd_loc_q)));

    // R5
    busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_req_q |-> (!miss_ready && !snoop_ready && !evict_ready));

    // R4
    moved_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_grant_q && fill_from_l1_q) |-> $past(cmd_req_q && cmd_ack && (cmd_op_q == OP_MOVE)));

    // R3
    no_early_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_req_q) |-> !fill_grant_q);

    // R8
    one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fill_grant_q, snoop_done_q, evict_done_q}));

endmodule

// File: rtl/synonym_bp_dir.sv
module synonym_bp_dir
    import synonym_bp_pkg::*;
#(
    parameter int L2_LINES = 64,
    parameter int L1_LINES = 32,
    localparam int AW      = $clog2(L2_LINES),
    localparam int LW      = $clog2(L1_LINES),
    localparam int ENT_W   = LW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    output logic             miss_ready,
    input  logic [AW-1:0]    miss_line,
    input  logic             miss_side,
    input  logic [LW-1:0]    miss_loc,
    output logic             fill_grant,
    output logic             fill_from_l1,
    output logic             fill_src_side,
    output logic [LW-1:0]    fill_src_loc,
    input  logic             snoop_valid,
    input  logic             snoop_is_write,
    input  logic [AW-1:0]    snoop_line,
    output logic             snoop_ready,
    output logic             snoop_done,
    input  logic             evict_valid,
    input  logic [AW-1:0]    evict_line,
    output logic             evict_ready,
    output logic             evict_done,
    input  logic             dir_we,
    input  logic [AW-1:0]    dir_addr,
    input  logic [ENT_W-1:0] dir_wdata,
    output logic [ENT_W-1:0] dir_rdata,
    output logic             l1_cmd_req,
    output logic [1:0]       l1_cmd_op,
    output logic             l1_cmd_side,
    output logic [LW-1:0]    l1_cmd_loc,
    input  logic             l1_cmd_ack
);

    logic [AW-1:0]    look_addr;
    logic [ENT_W-1:0] look_entry;
    logic             st_we;
    logic [AW-1:0]    st_addr;
    logic [ENT_W-1:0] st_wdata;
    l1_op_e           cmd_op;

    synonym_bp_store #(
        .L2_LINES (L2_LINES),
        .ENT_W    (ENT_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .waddr   (st_addr),
        .wdata   (st_wdata),
        .raddr_a (look_addr),
        .rdata_a (look_entry),
        .raddr_b (dir_addr),
        .rdata_b (dir_rdata)
    );

    synonym_bp_ctrl #(
        .L2_LINES (L2_LINES),
        .L1_LINES (L1_LINES)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_line      (miss_line),
        .miss_side      (miss_side),
        .miss_loc       (miss_loc),
        .miss_ready     (miss_ready),
        .snoop_valid    (snoop_valid),
        .snoop_is_write (snoop_is_write),
        .snoop_line     (snoop_line),
        .snoop_ready    (snoop_ready),
        .evict_valid    (evict_valid),
        .evict_line     (evict_line),
        .evict_ready    (evict_ready),
        .ext_we         (dir_we),
        .ext_addr       (dir_addr),
        .ext_wdata      (dir_wdata),
        .look_addr      (look_addr),
        .look_entry     (look_entry),
        .st_we          (st_we),
        .st_addr        (st_addr),
        .st_wdata       (st_wdata),
        .fill_grant     (fill_grant),
        .fill_from_l1   (fill_from_l1),
        .fill_src_side  (fill_src_side),
        .fill_src_loc   (fill_src_loc),
        .snoop_done     (snoop_done),
        .evict_done     (evict_done),
        .cmd_req        (l1_cmd_req),
        .cmd_op         (cmd_op),
        .cmd_side       (l1_cmd_side),
        .cmd_loc        (l1_cmd_loc),
        .cmd_ack        (l1_cmd_ack)
    );

    assign l1_cmd_op = cmd_op;

endmodule

// File: tb/synonym_bp_dir_tb.sv
module synonym_bp_dir_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss_valid = 1'b0, miss_side = 1'b0;
    logic [5:0] miss_line = '0;
    logic [4:0] miss_loc = '0;
    logic       miss_ready, fill_grant, fill_from_l1, fill_src_side;
    logic [4:0] fill_src_loc;
    logic       snoop_valid = 1'b0, snoop_is_write = 1'b0;
    logic [5:0] snoop_line = '0;
    logic       snoop_ready, snoop_done;
    logic       evict_valid = 1'b0;
    logic [5:0] evict_line = '0;
    logic       evict_ready, evict_done;
    logic       dir_we = 1'b0;
    logic [5:0] dir_addr = '0;
    logic [6:0] dir_wdata = '0;
    logic [6:0] dir_rdata;
    logic       l1_cmd_req, l1_cmd_side;
    logic [1:0] l1_cmd_op;
    logic [4:0] l1_cmd_loc;
    logic       l1_cmd_ack = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;

    localparam logic [1:0] OPC_INVAL  = 2'b01;
    localparam logic [1:0] OPC_MOVE   = 2'b10;
    localparam logic [1:0] OPC_SUPPLY = 2'b11;

    synonym_bp_dir u_dut (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_line(miss_line),
        .miss_side(miss_side), .miss_loc(miss_loc),
        .fill_grant(fill_grant), .fill_from_l1(fill_from_l1),
        .fill_src_side(fill_src_side), .fill_src_loc(fill_src_loc),
        .snoop_valid(snoop_valid), .snoop_is_write(snoop_is_write),
        .snoop_line(snoop_line), .snoop_ready(snoop_ready), .snoop_done(snoop_done),
        .evict_valid(evict_valid), .evict_line(evict_line),
        .evict_ready(evict_ready), .evict_done(evict_done),
        .dir_we(dir_we), .dir_addr(dir_addr), .dir_wdata(dir_wdata), .dir_rdata(dir_rdata),
        .l1_cmd_req(l1_cmd_req), .l1_cmd_op(l1_cmd_op), .l1_cmd_side(l1_cmd_side),
        .l1_cmd_loc(l1_cmd_loc), .l1_cmd_ack(l1_cmd_ack)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 20000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d expected<20000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    function automatic logic [6:0] ent(input logic v, input logic s, input logic [4:0] loc);
        return {v, s, loc};
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec = n_vec + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(input logic [5:0] line, input logic [6:0] exp, input string tag);
        dir_addr = line;
        #1;
        chk(dir_rdata == exp, tag, 32'(dir_rdata), 32'(exp));
    endtask

    task automatic poke(input logic [5:0] line, input logic [6:0] val);
        dir_we = 1'b1; dir_addr = line; dir_wdata = val;
        tick();
        dir_we = 1'b0;
    endtask

    task automatic ack_cycle();
        l1_cmd_ack = 1'b1;
        tick();
        l1_cmd_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk(l1_cmd_req == 1'b0, "R1 cmd_req", 32'(l1_cmd_req), 0);
        chk(miss_ready && snoop_ready && evict_ready, "R1 ready",
            {29'd0, miss_ready, snoop_ready, evict_ready}, 7);
        peek(6'd0, 7'd0, "R1 line0");
        peek(6'd63, 7'd0, "R1 line63");
    endtask

    task automatic t_miss_cold();
        miss_valid = 1'b1; miss_line = 6'd5; miss_side = 1'b1; miss_loc = 5'd7;
        tick();
        miss_valid = 1'b0;
        chk(fill_grant && !fill_from_l1, "R2 grant",
            {30'd0, fill_grant, fill_from_l1}, 32'b10);
        chk(l1_cmd_req == 1'b0, "R2 no cmd", 32'(l1_cmd_req), 0);
        peek(6'd5, ent(1, 1, 7), "R2 pointer");
        tick();
        chk(fill_grant == 1'b0, "R2 one cycle", 32'(fill_grant), 0);
    endtask

    task automatic t_miss_synonym();
        // R12: instruction-side miss on a line held by the data cache
        miss_valid = 1'b1; miss_line = 6'd5; miss_side = 1'b0; miss_loc = 5'd3;
        tick();
        miss_valid = 1'b0;
        chk(l1_cmd_req && l1_cmd_op == OPC_MOVE, "R3 move cmd",
            {29'd0, l1_cmd_req, l1_cmd_op}, {29'd0, 1'b1, OPC_MOVE});
        chk(l1_cmd_side == 1'b1 && l1_cmd_loc == 5'd7, "R12 target data side",
            {26'd0, l1_cmd_side, l1_cmd_loc}, {26'd0, 1'b1, 5'd7});
        chk(fill_grant == 1'b0, "R3 no grant yet", 32'(fill_grant), 0);
        // R5: hold without ack, try another miss meanwhile
        miss_valid = 1'b1; miss_line = 6'd9; miss_side = 1'b1; miss_loc = 5'd1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk(l1_cmd_req && l1_cmd_op == OPC_MOVE && l1_cmd_loc == 5'd7 && !fill_grant,
                "R5 held", {26'd0, l1_cmd_req, l1_cmd_loc}, {26'd0, 1'b1, 5'd7});
            chk(!miss_ready && !snoop_ready && !evict_ready, "R5 busy",
                {29'd0, miss_ready, snoop_ready, evict_ready}, 0);
        end
        miss_valid = 1'b0;
        peek(6'd9, 7'd0, "R5 refused miss left line9");
        ack_cycle();
        chk(fill_grant && fill_from_l1 && !l1_cmd_req, "R4 moved grant",
            {29'd0, fill_grant, fill_from_l1, l1_cmd_req}, 32'b110);
        chk(fill_src_side == 1'b1 && fill_src_loc == 5'd7, "R4 source",
            {26'd0, fill_src_side, fill_src_loc}, {26'd0, 1'b1, 5'd7});
        peek(6'd5, ent(1, 0, 3), "R12 pointer now instruction");
        tick();
        chk(fill_grant == 1'b0, "R4 one cycle", 32'(fill_grant), 0);
    endtask

    task automatic t_snoop_write();
        snoop_valid = 1'b1; snoop_is_write = 1'b1; snoop_line = 6'd5;
        tick();
        snoop_valid = 1'b0;
        chk(l1_cmd_req && l1_cmd_op == OPC_INVAL && l1_cmd_side == 1'b0 && l1_cmd_loc == 5'd3,
            "R6 inval cmd", {24'd0, l1_cmd_req, l1_cmd_op, l1_cmd_side, l1_cmd_loc},
            {24'd0, 1'b1, OPC_INVAL, 1'b0, 5'd3});
        chk(snoop_done == 1'b0, "R6 not done early", 32'(snoop_done), 0);
        ack_cycle();
        chk(snoop_done && !l1_cmd_req, "R6 done", {30'd0, snoop_done, l1_cmd_req}, 32'b10);
        peek(6'd5, 7'd0, "R6 pointer cleared");
    endtask

    task automatic t_snoop_read();
        poke(6'd10, ent(1, 1, 12));
        peek(6'd10, ent(1, 1, 12), "R11 write idle");
        snoop_valid = 1'b1; snoop_is_write = 1'b0; snoop_line = 6'd10;
        tick();
        snoop_valid = 1'b0;
        chk(l1_cmd_req && l1_cmd_op == OPC_SUPPLY && l1_cmd_side == 1'b1 && l1_cmd_loc == 5'd12,
            "R7 supply cmd", {24'd0, l1_cmd_req, l1_cmd_op, l1_cmd_side, l1_cmd_loc},
            {24'd0, 1'b1, OPC_SUPPLY, 1'b1, 5'd12});
        ack_cycle();
        chk(snoop_done == 1'b1, "R7 done", 32'(snoop_done), 1);
        peek(6'd10, 7'd0, "R7 pointer cleared");
    endtask

    task automatic t_invalid_ptr();
        snoop_valid = 1'b1; snoop_is_write = 1'b1; snoop_line = 6'd20;
        tick();
        snoop_valid = 1'b0;
        chk(snoop_done && !l1_cmd_req, "R8 snoop miss", {30'd0, snoop_done, l1_cmd_req}, 32'b10);
        evict_valid = 1'b1; evict_line = 6'd21;
        tick();
        evict_valid = 1'b0;
        chk(evict_done && !l1_cmd_req, "R8 evict miss", {30'd0, evict_done, l1_cmd_req}, 32'b10);
    endtask

    task automatic t_evict();
        poke(6'd30, ent(1, 0, 9));
        evict_valid = 1'b1; evict_line = 6'd30;
        tick();
        evict_valid = 1'b0;
        chk(l1_cmd_req && l1_cmd_op == OPC_INVAL && l1_cmd_side == 1'b0 && l1_cmd_loc == 5'd9,
            "R9 inval cmd", {24'd0, l1_cmd_req, l1_cmd_op, l1_cmd_side, l1_cmd_loc},
            {24'd0, 1'b1, OPC_INVAL, 1'b0, 5'd9});
        tick();
        chk(evict_done == 1'b0, "R9 waits for ack", 32'(evict_done), 0);
        ack_cycle();
        chk(evict_done == 1'b1, "R9 done", 32'(evict_done), 1);
        peek(6'd30, 7'd0, "R9 pointer cleared");
    endtask

    task automatic t_priority();
        poke(6'd40, ent(1, 1, 1));
        poke(6'd41, ent(1, 0, 2));
        snoop_valid = 1'b1; snoop_is_write = 1'b1; snoop_line = 6'd40;
        evict_valid = 1'b1; evict_line = 6'd41;
        miss_valid = 1'b1; miss_line = 6'd42; miss_side = 1'b1; miss_loc = 5'd4;
        #1;
        chk(snoop_ready && !evict_ready && !miss_ready, "R10 ready order",
            {29'd0, snoop_ready, evict_ready, miss_ready}, 32'b100);
        tick();
        snoop_valid = 1'b0;
        chk(l1_cmd_loc == 5'd1 && l1_cmd_side == 1'b1, "R10 snoop first",
            {26'd0, l1_cmd_side, l1_cmd_loc}, {26'd0, 1'b1, 5'd1});
        ack_cycle();
        chk(snoop_done && evict_ready && !miss_ready, "R10 evict next ready",
            {29'd0, snoop_done, evict_ready, miss_ready}, 32'b110);
        tick();
        evict_valid = 1'b0;
        chk(l1_cmd_req && l1_cmd_loc == 5'd2 && l1_cmd_side == 1'b0, "R10 evict second",
            {25'd0, l1_cmd_req, l1_cmd_side, l1_cmd_loc}, {25'd0, 1'b1, 1'b0, 5'd2});
        ack_cycle();
        chk(evict_done == 1'b1, "R10 evict done", 32'(evict_done), 1);
        tick();
        miss_valid = 1'b0;
        chk(fill_grant && !fill_from_l1, "R10 miss last", {30'd0, fill_grant, fill_from_l1}, 32'b10);
        peek(6'd42, ent(1, 1, 4), "R10 miss pointer");
    endtask

    task automatic t_dir_busy();
        poke(6'd50, ent(1, 1, 5));
        miss_valid = 1'b1; miss_line = 6'd50; miss_side = 1'b0; miss_loc = 5'd6;
        tick();
        miss_valid = 1'b0;
        chk(l1_cmd_req == 1'b1, "R11 busy setup", 32'(l1_cmd_req), 1);
        poke(6'd51, ent(1, 1, 9));
        peek(6'd51, 7'd0, "R11 write ignored busy");
        ack_cycle();
        peek(6'd50, ent(1, 0, 6), "R4 pointer after move");
        // write ignored while a request is presented in idle
        miss_valid = 1'b1; miss_line = 6'd52; miss_side = 1'b0; miss_loc = 5'd8;
        dir_we = 1'b1; dir_addr = 6'd53; dir_wdata = ent(1, 1, 3);
        tick();
        miss_valid = 1'b0; dir_we = 1'b0;
        peek(6'd53, 7'd0, "R11 write ignored with request");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_cold();
        t_miss_synonym();
        t_snoop_write();
        t_snoop_read();
        t_invalid_ptr();
        t_evict();
        t_priority();
        t_dir_busy();
        tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule